// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt request lines and drives two active-low processor lines: a normal interrupt (`irq_n`) and a fast interrupt (`fiq_n`). Each source has its own trigger style, polarity, three-bit priority, enable bit and vector word. Among the normal sources, the block picks the most urgent eligible request. It raises `irq_n` only when that request outranks the level now in service, so a more urgent request can nest on top of the current one.

Software works through a small word-addressed register bus. A vector read hands the handler address to the processor and pushes the new service level onto an eight-entry level stack. An end-of-service write pops that stack. Source 0 and any source selected for fast forcing drive the fast line and never take part in normal arbitration. A debug protect mode keeps vector reads free of side effects. A global mask holds both processor lines inactive while the pending word stays readable.

Word addresses: 0..31 vector of source n; 32..63 mode of source n-32; 64 enable mask; 65 fast-force mask; 66 global mask (bit 0); 67 protect (bit 0); 68 spurious vector; 69 pending word (read only); 70 interrupt vector; 71 fast vector; 72 edge-clear (write only); 73 end of service (write only). Undecoded reads return zero.

Top module: `vpic_top`

## Requirements
- R1: Source 0 is always routed to `fiq_n` (when its enable bit is set) and is never chosen by normal arbitration. A read of word 71 returns the vector of source 0 and, outside protect mode, clears its edge latch.
- R2: Mode word bits: [2:0] priority, bit 4 selects edge trigger (1) or level (0), bit 5 selects low-active: a falling edge or a low level (1) instead of a rising edge or a high level (0). The word reads back with the other bits zero.
- R3: Among pending, enabled, non-forced sources 1..31, the one with the highest priority value wins. On equal priority the lower source number wins.
- R4: `irq_n` is asserted only when the winner's priority is strictly greater than the top of the level stack, or when the stack is empty. The stack never holds more than 8 entries.
- R5: A read of word 70 returns the winner's vector when R4 allows it, and the spurious vector otherwise. Outside protect mode, a read that returns a winner's vector pushes the winner's priority and clears the winner's edge latch.
- R6: A write to word 73 pops one stack entry. It has no effect when the stack is empty.
- R7: With protect set, reads of words 70 and 71 change no state. A write to word 70 (or 71) instead performs the acknowledge that the read would perform.
- R8: A source whose bit is set in the fast-force mask drives `fiq_n` instead of `irq_n`.
- R9: With the global mask set, both outputs are held high from the next clock on. The pending word (69) still reports the raw pending state of every source, ignoring enables.
- R10: Source inputs pass through two synchronizing flops. A level change drives the outputs after the third rising edge; an edge-triggered request drives them after the fourth.
- R11: A source whose enable bit (word 64) is clear shows in the pending word but drives neither output.
- R12: Writing 1s to word 72 clears those sources' edge latches. An edge detected in the same cycle as the clear wins, and the latch stays set.
- R13: After reset, both outputs are high, all registers read zero and the level stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 32 | Asynchronous interrupt request lines, bit n is source n |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_en` |
| irq_n | output | 1 | Normal interrupt, active low, registered |
| fiq_n | output | 1 | Fast interrupt, active low, registered |

## Verification
A wrong level on the stack shows at the ports one clock later. `irq_n` either fails to fall for a more urgent request or falls again for a request already in service. The next vector read then returns a real vector where the spurious one was due, or the reverse. A stuck or lost edge latch shows in the pending word within the same cycle, and on `irq_n`/`fiq_n` one clock later. The bench runs a behavioural model beside the design and compares both outputs every cycle, and the read data on every read. A fault in arbitration, nesting, masking or synchronizer latency therefore surfaces at the first cycle where the two disagree.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int PRIO_W    = 3;
    localparam int LEVELS    = 1 << PRIO_W;
    localparam int ADDR_W    = 8;
    localparam int MAX_SRC   = 32;

    // word addresses of the control registers
    localparam logic [ADDR_W-1:0] A_MODE_BASE = 8'd32;
    localparam logic [ADDR_W-1:0] A_ENABLE    = 8'd64;
    localparam logic [ADDR_W-1:0] A_FAST      = 8'd65;
    localparam logic [ADDR_W-1:0] A_GMASK     = 8'd66;
    localparam logic [ADDR_W-1:0] A_PROTECT   = 8'd67;
    localparam logic [ADDR_W-1:0] A_SPUR      = 8'd68;
    localparam logic [ADDR_W-1:0] A_PEND      = 8'd69;
    localparam logic [ADDR_W-1:0] A_IVEC      = 8'd70;
    localparam logic [ADDR_W-1:0] A_FVEC      = 8'd71;
    localparam logic [ADDR_W-1:0] A_ECLR      = 8'd72;
    localparam logic [ADDR_W-1:0] A_EOS       = 8'd73;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic  low_active;
        logic  edge_trig;
        prio_t prio;
    } src_mode_t;

    typedef enum logic [3:0] {
        K_NONE, K_VEC, K_MODE, K_ENABLE, K_FAST, K_GMASK, K_PROTECT,
        K_SPUR, K_PEND, K_IVEC, K_FVEC, K_ECLR, K_EOS
    } reg_kind_e;

    function automatic src_mode_t mode_from_word(logic [31:0] w);
        src_mode_t m;
        m.prio       = w[PRIO_W-1:0];
        m.edge_trig  = w[4];
        m.low_active = w[5];
        return m;
    endfunction

    function automatic logic [31:0] mode_to_word(src_mode_t m);
        logic [31:0] w;
        w = '0;
        w[PRIO_W-1:0] = m.prio;
        w[4] = m.edge_trig;
        w[5] = m.low_active;
        return w;
    endfunction

    function automatic reg_kind_e classify(logic [ADDR_W-1:0] a);
        if (a < A_MODE_BASE) return K_VEC;
        if (a < A_ENABLE)    return K_MODE;
        case (a)
            A_ENABLE:  return K_ENABLE;
            A_FAST:    return K_FAST;
            A_GMASK:   return K_GMASK;
            A_PROTECT: return K_PROTECT;
            A_SPUR:    return K_SPUR;
            A_PEND:    return K_PEND;
            A_IVEC:    return K_IVEC;
            A_FVEC:    return K_FVEC;
            A_ECLR:    return K_ECLR;
            A_EOS:     return K_EOS;
            default:   return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/vpic_src_detect.sv
// One request line: two-flop synchronizer, edge detector with latch, level path.
module vpic_src_detect (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic edge_trig,
    input  logic low_active,
    input  logic clr,
    output logic pending
);
    logic [2:0] hist;    // [0] first sync flop, [1] synchronized, [2] previous
    logic       latch_q;
    logic       sync_v;
    logic       prev_v;
    logic       edge_seen;

    assign sync_v = hist[1];
    assign prev_v = hist[2];

    always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else     hist <= {hist[1:0], raw};
    end

    assign edge_seen = edge_trig &&
                       (low_active ? (prev_v && !sync_v) : (!prev_v && sync_v));

    always_ff @(posedge clk) begin
        if (rst)            latch_q <= 1'b0;
        else if (edge_seen) latch_q <= 1'b1;
        else if (clr)       latch_q <= 1'b0;
    end

    assign pending = edge_trig ? latch_q : (sync_v ^ low_active);

endmodule

// File: rtl/vpic_arbiter.sv
// Picks the highest priority candidate; ties go to the lowest index.
module vpic_arbiter
    import vpic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             cand,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prios,
    output logic                           valid,
    output logic [IDX_W-1:0]               idx,
    output prio_t                          prio
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        prio  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!valid || prios[i] > prio)) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
                prio  = prios[i];
            end
        end
    end
endmodule

// File: rtl/vpic_level_stack.sv
// Stack of service levels; a push only ever holds a strictly higher level.
module vpic_level_stack
    import vpic_pkg::*;
#(
    parameter int  DEPTH   = LEVELS,
    localparam int DEPTH_W = $clog2(DEPTH + 1),
    localparam int PTR_W   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  prio_t              push_val,
    input  logic               pop,
    output logic [DEPTH_W-1:0] depth,
    output prio_t              top,
    output logic               empty
);
    prio_t              ent [DEPTH];
    logic [DEPTH_W-1:0] dm1;

    assign empty = (depth == '0);
    assign dm1   = depth - DEPTH_W'(1);
    assign top   = empty ? '0 : ent[dm1[PTR_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else if (push && (int'(depth) < DEPTH)) begin
            ent[depth[PTR_W-1:0]] <= push_val;
            depth <= depth + DEPTH_W'(1);
        end else if (pop && !empty) begin
            depth <= dm1;
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int  NUM_SRC = 32,
    parameter int  DATA_W  = 32,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int DEPTH_W = $clog2(LEVELS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n,
    output logic               fiq_n
);
    // configuration state
    logic [DATA_W-1:0]  vec_q  [NUM_SRC];
    src_mode_t          mode_q [NUM_SRC];
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] fast_q;
    logic               gmask_q;
    logic               protect_q;
    logic [DATA_W-1:0]  spur_q;

    // datapath
    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0]             clr_vec;
    logic [NUM_SRC-1:0]             fast_sel;
    logic [NUM_SRC-1:0]             cand;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prios;
    logic                           arb_valid;
    logic [IDX_W-1:0]               arb_idx;
    prio_t                          arb_prio;
    logic [DEPTH_W-1:0]             stk_depth;
    prio_t                          stk_top;
    logic                           stk_empty;
    logic                           elig;

    // bus decode
    reg_kind_e        kind;
    logic [IDX_W-1:0] src_ix;
    logic             idx_ok;
    logic             bus_wr;
    logic             bus_rd;
    logic             ivec_ack;
    logic             fvec_ack;
    logic             push;
    logic             pop;

    assign kind   = classify(bus_addr);
    assign src_ix = bus_addr[IDX_W-1:0];
    assign idx_ok = int'(bus_addr[4:0]) < NUM_SRC;
    assign bus_wr = bus_en && bus_we;
    assign bus_rd = bus_en && !bus_we;

    // acknowledge happens on read normally, on write in protect mode
    assign ivec_ack = (kind == K_IVEC) && (protect_q ? bus_wr : bus_rd);
    assign fvec_ack = (kind == K_FVEC) && (protect_q ? bus_wr : bus_rd);
    assign pop      = bus_wr && (kind == K_EOS);

    // per-source detection
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        vpic_src_detect u_det (
            .clk        (clk),
            .rst        (rst),
            .raw        (src_in[g]),
            .edge_trig  (mode_q[g].edge_trig),
            .low_active (mode_q[g].low_active),
            .clr        (clr_vec[g]),
            .pending    (pend[g])
        );
        assign prios[g] = mode_q[g].prio;
    end

    // source 0 is always on the fast line
    always_comb begin
        fast_sel    = fast_q;
        fast_sel[0] = 1'b1;
    end

    assign cand = pend & en_q & ~fast_sel;

    vpic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .cand  (cand),
        .prios (prios),
        .valid (arb_valid),
        .idx   (arb_idx),
        .prio  (arb_prio)
    );

    assign elig = arb_valid && (stk_empty || (arb_prio > stk_top));
    assign push = ivec_ack && elig;

    vpic_level_stack #(.DEPTH(LEVELS)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_val (arb_prio),
        .pop      (pop),
        .depth    (stk_depth),
        .top      (stk_top),
        .empty    (stk_empty)
    );

    // edge latch clears from acknowledge and from the clear register
    always_comb begin
        clr_vec = '0;
        if (push)                         clr_vec[arb_idx] = 1'b1;
        if (fvec_ack)                     clr_vec[0] = 1'b1;
        if (bus_wr && (kind == K_ECLR))   clr_vec = clr_vec | bus_wdata[NUM_SRC-1:0];
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                vec_q[i]  <= '0;
                mode_q[i] <= '0;
            end
            en_q      <= '0;
            fast_q    <= '0;
            gmask_q   <= 1'b0;
            protect_q <= 1'b0;
            spur_q    <= '0;
        end else if (bus_wr) begin
            case (kind)
                K_VEC:     if (idx_ok) vec_q[src_ix]  <= bus_wdata;
                K_MODE:    if (idx_ok) mode_q[src_ix] <= mode_from_word(32'(bus_wdata));
                K_ENABLE:  en_q      <= bus_wdata[NUM_SRC-1:0];
                K_FAST:    fast_q    <= bus_wdata[NUM_SRC-1:0];
                K_GMASK:   gmask_q   <= bus_wdata[0];
                K_PROTECT: protect_q <= bus_wdata[0];
                K_SPUR:    spur_q    <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (kind)
            K_VEC:     if (idx_ok) bus_rdata = vec_q[src_ix];
            K_MODE:    if (idx_ok) bus_rdata = DATA_W'(mode_to_word(mode_q[src_ix]));
            K_ENABLE:  bus_rdata[NUM_SRC-1:0] = en_q;
            K_FAST:    bus_rdata[NUM_SRC-1:0] = fast_q;
            K_GMASK:   bus_rdata[0] = gmask_q;
            K_PROTECT: bus_rdata[0] = protect_q;
            K_SPUR:    bus_rdata = spur_q;
            K_PEND:    bus_rdata[NUM_SRC-1:0] = pend;
            K_IVEC:    bus_rdata = elig ? vec_q[arb_idx] : spur_q;
            K_FVEC:    bus_rdata = vec_q[0];
            default:   bus_rdata = '0;
        endcase
    end

    // registered processor lines
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_n <= 1'b1;
            fiq_n <= 1'b1;
        end else begin
            irq_n <= !(elig && !gmask_q);
            fiq_n <= !((|(pend & en_q & fast_sel)) && !gmask_q);
        end
    end

endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
    import vpic_pkg::*;
#(
    parameter int  NUM_SRC = 32,
    localparam int IDX_W   = $clog2(NUM_SRC),
    localparam int DEPTH_W = $clog2(LEVELS + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_n,
    input logic               fiq_n,
    input logic               gmask_q,
    input logic               protect_q,
    input logic               bus_en,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               arb_valid,
    input logic [IDX_W-1:0]   arb_idx,
    input logic               push,
    input logic               pop,
    input logic [DEPTH_W-1:0] stk_depth
);
    // R13
    reset_idle_chk: assert property (@(posedge clk) rst |=> (irq_n && fiq_n));

    // R9
    gmask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        gmask_q |=> (irq_n && fiq_n));

    // R1
    fast_excl_chk: assert property (@(posedge clk) disable iff (rst)
        arb_valid |-> (arb_idx != '0));

    // R4
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(stk_depth) <= LEVELS);

    // R5
    push_depth_chk: assert property (@(posedge clk) disable iff (rst)
        push |=> (stk_depth == $past(stk_depth) + DEPTH_W'(1)));

    // R6
    eos_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && stk_depth != '0) |=> (stk_depth == $past(stk_depth) - DEPTH_W'(1)));

    // R7
    protect_read_chk: assert property (@(posedge clk) disable iff (rst)
        (protect_q && bus_en && !bus_we && bus_addr == A_IVEC) |=> $stable(stk_depth));

endmodule

bind vpic_top vpic_chk #(.NUM_SRC(NUM_SRC)) u_vpic_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_n     (irq_n),
    .fiq_n     (fiq_n),
    .gmask_q   (gmask_q),
    .protect_q (protect_q),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .arb_valid (arb_valid),
    .arb_idx   (arb_idx),
    .push      (push),
    .pop       (pop),
    .stk_depth (stk_depth)
);

// File: tb/test_vpic_top.sv
module test_vpic_top;

    localparam int MB = 32, EN = 64, FST = 65, GM = 66, PR = 67, SP = 68,
                   PN = 69, IV = 70, FV = 71, EC = 72, EO = 73;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_in = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n, fiq_n;

    int    checks = 0;
    int    errors = 0;
    bit    seen_edge = 0;
    bit    done = 0;
    string cur_req = "R13";

    // 50 MHz: 20 ns period
    always #10 clk = ~clk;

    vpic_top i_vpic_top (
        .clk(clk), .rst(rst), .src_in(src_in),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_n(irq_n), .fiq_n(fiq_n)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_s1, m_s2, m_s3, m_lat;
    logic [31:0] m_vec [32];
    logic [2:0]  m_pr  [32];
    logic [31:0] m_edge, m_pol, m_en, m_fast;
    logic        m_gm, m_prot;
    logic [31:0] m_spur;
    int          m_stack [$];
    logic        m_irq_n = 1'b1, m_fiq_n = 1'b1;

    function automatic logic [31:0] m_pend();
        logic [31:0] p;
        for (int i = 0; i < 32; i++)
            p[i] = m_edge[i] ? m_lat[i] : (m_s2[i] ^ m_pol[i]);
        return p;
    endfunction

    function automatic int m_best();
        logic [31:0] p = m_pend();
        int b = -1;
        int bp = -1;
        for (int i = 1; i < 32; i++)
            if (p[i] && m_en[i] && !m_fast[i] && int'(m_pr[i]) > bp) begin
                b = i;
                bp = int'(m_pr[i]);
            end
        return b;
    endfunction

    function automatic bit m_elig(int b);
        if (b < 0) return 0;
        if (m_stack.size() == 0) return 1;
        return int'(m_pr[b]) > m_stack[$];
    endfunction

    function automatic logic [31:0] m_rdata(int a);
        int b;
        if (a < 32) return m_vec[a];
        if (a < 64) return {26'b0, m_pol[a-32], m_edge[a-32], 1'b0, m_pr[a-32]};
        case (a)
            EN:  return m_en;
            FST: return m_fast;
            GM:  return {31'b0, m_gm};
            PR:  return {31'b0, m_prot};
            SP:  return m_spur;
            PN:  return m_pend();
            IV: begin
                b = m_best();
                return m_elig(b) ? m_vec[b] : m_spur;
            end
            FV:  return m_vec[0];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] p, clrm;
        int b;
        bit el, fa, ack;
        seen_edge = 1;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_lat = 0;
            for (int i = 0; i < 32; i++) begin m_vec[i] = 0; m_pr[i] = 0; end
            m_edge = 0; m_pol = 0; m_en = 0; m_fast = 0;
            m_gm = 0; m_prot = 0; m_spur = 0;
            m_stack.delete();
            m_irq_n = 1; m_fiq_n = 1;
        end else begin
            p  = m_pend();
            b  = m_best();
            el = m_elig(b);
            fa = |(p & m_en & (m_fast | 32'h1));
            clrm = 0;
            ack  = 0;
            if (bus_en && bus_we) begin
                if (bus_addr == IV && m_prot) ack = 1;
                if (bus_addr == FV && m_prot) clrm[0] = 1;
                if (bus_addr == EC) clrm = clrm | bus_wdata;
                if (bus_addr == EO && m_stack.size() > 0) void'(m_stack.pop_back());
            end
            if (bus_en && !bus_we) begin
                if (bus_addr == IV && !m_prot) ack = 1;
                if (bus_addr == FV && !m_prot) clrm[0] = 1;
            end
            if (ack && el) begin
                m_stack.push_back(int'(m_pr[b]));
                clrm[b] = 1;
            end
            for (int i = 0; i < 32; i++) begin
                if (m_edge[i] && (m_pol[i] ? (m_s3[i] && !m_s2[i]) : (!m_s3[i] && m_s2[i])))
                    m_lat[i] = 1;
                else if (clrm[i])
                    m_lat[i] = 0;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = src_in;
            m_irq_n = !(el && !m_gm);
            m_fiq_n = !(fa && !m_gm);
            if (bus_en && bus_we) begin
                if (bus_addr < 32) m_vec[bus_addr] = bus_wdata;
                else if (bus_addr < 64) begin
                    m_pr[bus_addr-32]   = bus_wdata[2:0];
                    m_edge[bus_addr-32] = bus_wdata[4];
                    m_pol[bus_addr-32]  = bus_wdata[5];
                end else case (bus_addr)
                    EN:  m_en   = bus_wdata;
                    FST: m_fast = bus_wdata;
                    GM:  m_gm   = bus_wdata[0];
                    PR:  m_prot = bus_wdata[0];
                    SP:  m_spur = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- comparison, away from the clock edge ----------------
    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (seen_edge && !done) begin
            cmp("irq_n", {31'b0, irq_n}, {31'b0, m_irq_n});
            cmp("fiq_n", {31'b0, fiq_n}, {31'b0, m_fiq_n});
            if (bus_en && !bus_we)
                cmp($sformatf("rdata@%0d", bus_addr), bus_rdata, m_rdata(int'(bus_addr)));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 8'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(int a);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = 8'(a);
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic set_src(int i, logic v);
        @(negedge clk);
        src_in[i] = v;
    endtask

    task automatic pulse(int i);
        set_src(i, 1);
        idle(1);
        set_src(i, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // watchdog: counts as a failed check
    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] en_mask;
        // R13 reset state
        cur_req = "R13";
        rst = 1;
        idle(3);
        rst = 0;
        idle(2);
        rd(EN); rd(PN); rd(IV); rd(MB + 3); rd(SP);

        for (int i = 0; i < 32; i++) wr(i, 32'h0000_1000 + i * 16);
        wr(SP, 32'hBAD0_0BAD);

        // R10 latency of a level request (and R2 level high)
        cur_req = "R10";
        wr(MB + 3, 32'h2);
        en_mask = 32'h8;
        wr(EN, en_mask);
        set_src(3, 1);
        idle(5);

        // R5 vector read, push, then spurious
        cur_req = "R5";
        rd(IV);
        idle(3);
        rd(IV);

        // R4 nesting: higher priority edge nests, lower level does not
        cur_req = "R4";
        wr(MB + 5, 32'h15);
        en_mask |= 32'h20;
        wr(EN, en_mask);
        pulse(5);
        idle(5);
        rd(IV);
        wr(MB + 7, 32'h1);
        en_mask |= 32'h80;
        wr(EN, en_mask);
        set_src(7, 1);
        idle(5);

        // R6 end of service pops
        cur_req = "R6";
        wr(EO, 0); idle(3);
        wr(EO, 0); idle(3);
        rd(IV); idle(2);
        set_src(3, 0); set_src(7, 0);
        wr(EO, 0); wr(EO, 0); idle(3);

        // R3 equal priorities: lower number wins
        cur_req = "R3";
        wr(MB + 10, 32'h4); wr(MB + 12, 32'h4);
        en_mask |= 32'h1400;
        wr(EN, en_mask);
        set_src(12, 1); set_src(10, 1);
        idle(4);
        rd(IV); wr(EO, 0);
        set_src(10, 0);
        idle(4);
        rd(IV); wr(EO, 0);
        set_src(12, 0);
        idle(4);

        // R2 falling edge and low level
        cur_req = "R2";
        wr(MB + 14, 32'h33);
        wr(MB + 15, 32'h21);
        rd(MB + 14);
        en_mask |= 32'hC000;
        wr(EN, en_mask);
        idle(4);
        rd(PN);
        set_src(14, 1); idle(5); rd(PN);
        set_src(14, 0); idle(5); rd(PN);
        rd(IV); wr(EO, 0);
        set_src(15, 1); idle(4); rd(PN);
        rd(IV); wr(EO, 0); idle(3);

        // R7 protect mode
        cur_req = "R7";
        wr(PR, 1);
        wr(MB + 20, 32'h16);
        en_mask |= 32'h0010_0000;
        wr(EN, en_mask);
        pulse(20);
        idle(5);
        rd(IV); rd(IV); rd(PN);
        wr(IV, 0);
        rd(PN); rd(IV);
        wr(EO, 0);
        pulse(0);
        en_mask |= 32'h1;
        wr(EN, en_mask);
        wr(MB + 0, 32'h10);
        pulse(0); idle(5);
        rd(FV); rd(PN);
        wr(FV, 0); idle(2); rd(PN);
        wr(PR, 0);
        idle(3);

        // R8 fast forcing
        cur_req = "R8";
        wr(FST, 32'h0020_0000);
        wr(MB + 21, 32'h7);
        en_mask |= 32'h0020_0000;
        wr(EN, en_mask);
        set_src(21, 1);
        idle(5);
        rd(IV);
        set_src(21, 0);
        idle(4);
        wr(FST, 0);

        // R1 source 0 on the fast line, fast vector read clears it
        cur_req = "R1";
        pulse(0);
        idle(5);
        rd(IV);
        rd(FV);
        idle(3);
        rd(PN);

        // R9 global mask
        cur_req = "R9";
        wr(GM, 1);
        set_src(3, 1);
        pulse(0);
        idle(5);
        rd(PN); rd(GM);
        wr(GM, 0);
        idle(2);
        rd(IV); rd(FV);
        wr(EO, 0);
        set_src(3, 0);
        idle(4);

        // R11 disabled source
        cur_req = "R11";
        en_mask &= ~32'h8;
        wr(EN, en_mask);
        set_src(3, 1);
        idle(5);
        rd(PN); rd(IV);
        set_src(3, 0);
        idle(4);

        // R12 edge clear, and edge winning over a same-cycle clear
        cur_req = "R12";
        pulse(5);
        idle(5);
        rd(PN);
        wr(EC, 32'h20);
        idle(2);
        rd(PN);
        set_src(5, 1);
        idle(1);
        wr(EC, 32'h20);
        idle(2);
        rd(PN);
        set_src(5, 0);
        wr(EC, 32'h20);
        idle(3);

        // R4 mixed traffic against the model
        cur_req = "R4";
        for (int i = 1; i < 32; i++) wr(MB + i, $urandom & 32'h37);
        wr(EN, $urandom | 32'h1);
        wr(FST, $urandom & 32'h0101_0100);
        for (int r = 0; r < 120; r++) begin
            @(negedge clk);
            src_in = $urandom;
            idle($urandom_range(1, 4));
            case ($urandom_range(0, 4))
                0, 1: rd(IV);
                2:    wr(EO, 0);
                3:    rd(PN);
                default: wr(EC, $urandom);
            endcase
        end
        src_in = 0;
        idle(6);

        finish_run();
    end

endmodule